// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block gathers up to eight asynchronous interrupt pins from outside the chip and turns them into clean, maskable interrupt requests. Each pin goes through a two-flop synchroniser. A per-pin trigger code selects one of five conditions: falling edge, rising edge, both edges, low level or high level. A detected condition sets a sticky pending bit, which software clears by writing zero to that bit's position in the source register.

A pending pin raises its request only when three things hold: it is unmasked, its priority nibble is non-zero, and, for the per-pin outputs, the individual-request mode bit is set. Masking uses two write-only registers, one that sets mask bits and one that clears them, so no read-modify-write is needed. The combined output is the OR of all per-pin requests. Software reaches the block over a single-cycle register port with combinational read data.

Top module: `extirq_pin_ctrl`

## Requirements
- R1: After reset, the trigger, priority and mode registers and the source register read 0. Every pin is masked, and no request output is high.
- R2: The trigger register at address 0 is read/write and 32 bits wide. Pin n's field is SENSE_W bits at bit offset 32-(n+1)*SENSE_W, so pin 0 holds the top field.
- R3: Edge codes are 0 for falling, 1 for rising and 4 for either edge. A qualifying pin transition sets the pending bit on the third rising clock edge after the pin changes, and not earlier.
- R4: Code 2 (low) and code 3 (high) set the pending bit while the pin sits at that level. A clear write issued while the level persists leaves the bit set.
- R5: In the source register (address 2), pin n appears at bit SRC_W-1-n. Writing 0 at a pin's position clears its pending bit. Writing 1 leaves the bit unchanged. Writing all zeros clears every pending bit.
- R6: A 1 written at a pin's position in address 3 masks that pin, and a 1 written at its position in address 4 unmasks it. A 0 at a position has no effect in either register. Reads of addresses 3 and 4 return 0.
- R7: The priority register (address 1) holds a 4-bit field for pin n at offset 32-(n+1)*4. A zero field blocks that pin's request, and any non-zero field lets it through. The pending bit stays visible in the source register either way.
- R8: Bit 23 of the mode register (address 5) enables the per-pin outputs. With the bit set, irq_pin_o[n] carries pin n's request. With it clear, every irq_pin_o bit is 0 and irq_any_o still reports requests.
- R9: irq_any_o is the OR of all per-pin requests, each request being pending AND unmasked AND priority non-zero.
- R10: Trigger codes 5 to 15 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, pin 0 in bit 0 |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select 0 to 5 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_pin_o | output | NUM_PINS | Per-pin request, pin n in bit n |
| irq_any_o | output | 1 | OR of all pin requests |

## Verification
A pin change takes effect on the third rising edge after it is driven: two synchroniser stages, then the edge register together with the pending flop. The bench drives pins on falling edges. It checks that the source register is still clear after two rising edges and that the bit is set after the third. Register writes take effect on the next rising edge and the request outputs follow combinationally, so they are sampled on the following falling edge. Reads are combinational and are sampled one time unit after the address is driven.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   localparam int REG_W = 32;
   localparam int PRIO_W = 4;

   localparam logic [2:0] A_SENSE  = 3'd0;
   localparam logic [2:0] A_PRIO   = 3'd1;
   localparam logic [2:0] A_SOURCE = 3'd2;
   localparam logic [2:0] A_MSET   = 3'd3;
   localparam logic [2:0] A_MCLR   = 3'd4;
   localparam logic [2:0] A_MODE   = 3'd5;

   typedef enum logic [3:0] {
      TRIG_FALL = 4'd0,
      TRIG_RISE = 4'd1,
      TRIG_LOW  = 4'd2,
      TRIG_HIGH = 4'd3,
      TRIG_BOTH = 4'd4
   } trig_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_sense_det.sv
module extirq_sense_det
   import extirq_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              clr_i,
   output logic              pend_o
);
   logic       prev_q;
   logic       pend_q;
   logic       hit;
   logic [3:0] code4;

   assign code4 = 4'(code_i);

   always_comb begin
      case (code4)
         TRIG_FALL: hit = prev_q & ~lvl_i;
         TRIG_RISE: hit = ~prev_q & lvl_i;
         TRIG_LOW:  hit = ~lvl_i;
         TRIG_HIGH: hit = lvl_i;
         TRIG_BOTH: hit = prev_q ^ lvl_i;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         pend_q <= (pend_q & ~clr_i) | hit;
      end
   end

   assign pend_o = pend_q;

   // R5: a pending bit only drops through a clear write
   p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i) |=> pend_q);

   // R10: unused codes never raise pending
   p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (code4 > 4'd4 && !pend_q) |=> !pend_q);
endmodule

// File: rtl/extirq_regfile.sv
module extirq_regfile
   import extirq_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SENSE_W  = 4,
   parameter int SRC_W    = 8,
   parameter int MODE_BIT = 23,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_valid,
   input  logic                              bus_write,
   input  logic [2:0]                        bus_addr,
   input  logic [REG_W-1:0]                  bus_wdata,
   output logic [REG_W-1:0]                  bus_rdata,
   input  logic [NUM_PINS-1:0]               pend_i,
   output logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_o,
   output logic [NUM_PINS-1:0]               prio_nz_o,
   output logic [NUM_PINS-1:0]               mask_o,
   output logic [NUM_PINS-1:0]               clr_o,
   output logic                              indiv_o
);
   logic             wr;
   logic [REG_W-1:0] sense_q;
   logic [REG_W-1:0] prio_q;
   logic [REG_W-1:0] mode_rd;
   logic [SRC_W-1:0] src_vec;

   assign wr = bus_valid & bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         prio_q  <= '0;
      end else if (wr) begin
         if (bus_addr == A_SENSE) sense_q <= bus_wdata;
         if (bus_addr == A_PRIO)  prio_q  <= bus_wdata;
      end
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam int SOFF = REG_W - (n + 1) * SENSE_W;
      localparam int POFF = REG_W - (n + 1) * PRIO_W;
      localparam int SBIT = SRC_W - 1 - n;

      assign sense_o[n]   = sense_q[SOFF +: SENSE_W];
      assign prio_nz_o[n] = |prio_q[POFF +: PRIO_W];
      assign clr_o[n]     = wr && (bus_addr == A_SOURCE) && !bus_wdata[SBIT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mask_o[n] <= 1'b1;
         else if (wr && bus_wdata[SBIT]) begin
            if (bus_addr == A_MSET)      mask_o[n] <= 1'b1;
            else if (bus_addr == A_MCLR) mask_o[n] <= 1'b0;
         end
      end

      // R6: a 1 at the pin position in the set register masks it
      p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == A_MSET && bus_wdata[SBIT]) |=> mask_o[n]);

      // R6: a 0 at the pin position leaves the mask alone
      p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && (bus_addr == A_MSET || bus_addr == A_MCLR) && !bus_wdata[SBIT])
            |=> $stable(mask_o[n]));
   end

   always_comb begin
      src_vec = '0;
      for (int n = 0; n < NUM_PINS; n++) src_vec[SRC_W-1-n] = pend_i[n];
   end

   if (HAS_MODE) begin : g_mode
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mode_q <= 1'b0;
         else if (wr && bus_addr == A_MODE) mode_q <= bus_wdata[MODE_BIT];
      end
      assign indiv_o = mode_q;
      always_comb begin
         mode_rd = '0;
         mode_rd[MODE_BIT] = mode_q;
      end
   end else begin : g_no_mode
      assign indiv_o = 1'b1;
      assign mode_rd = '0;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_SENSE:  bus_rdata = sense_q;
         A_PRIO:   bus_rdata = prio_q;
         A_SOURCE: bus_rdata = REG_W'(src_vec);
         A_MODE:   bus_rdata = mode_rd;
         default:  bus_rdata = '0;
      endcase
   end

   // R6: the mask registers read as zero
   p_rd_wo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && (bus_addr == A_MSET || bus_addr == A_MCLR))
         |-> bus_rdata == '0);
endmodule

// File: rtl/extirq_pin_ctrl.sv
module extirq_pin_ctrl
   import extirq_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SENSE_W     = 4,
   parameter int SRC_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_BIT    = 23,
   parameter bit HAS_MODE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [2:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] irq_pin_o,
   output logic                irq_any_o
);
   initial begin
      a_pins_range: assert (NUM_PINS >= 1 && NUM_PINS <= 8);
      a_sense_width: assert (SENSE_W == 2 || SENSE_W == 4);
      a_src_width: assert (SRC_W == 8 || SRC_W == 32);
      a_sync_depth: assert (SYNC_STAGES >= 2);
      a_mode_bit: assert (MODE_BIT >= 0 && MODE_BIT < REG_W);
   end

   logic [NUM_PINS-1:0]              lvl;
   logic [NUM_PINS-1:0]              pend;
   logic [NUM_PINS-1:0]              mask;
   logic [NUM_PINS-1:0]              clr;
   logic [NUM_PINS-1:0]              prio_nz;
   logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
   logic [NUM_PINS-1:0]              req;
   logic                             indiv;

   extirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_det
      extirq_sense_det #(.CODE_W(SENSE_W)) i_det (
         .clk(clk), .rst_n(rst_n), .lvl_i(lvl[n]), .code_i(sense[n]),
         .clr_i(clr[n]), .pend_o(pend[n])
      );

      // R7: zero priority blocks the pin's output
      p_prio_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !prio_nz[n] |-> !irq_pin_o[n]);
   end

   extirq_regfile #(
      .NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W), .SRC_W(SRC_W),
      .MODE_BIT(MODE_BIT), .HAS_MODE(HAS_MODE)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pend_i(pend), .sense_o(sense), .prio_nz_o(prio_nz),
      .mask_o(mask), .clr_o(clr), .indiv_o(indiv)
   );

   assign req       = pend & ~mask & prio_nz;
   assign irq_pin_o = indiv ? req : '0;
   assign irq_any_o = |req;

   // R8: per-pin outputs silent outside individual mode
   p_group_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !indiv |-> irq_pin_o == '0);

   // R9: any per-pin request shows on the combined output
   p_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pin_o != '0) |-> irq_any_o);

   // R1: nothing pending right after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_any_o);
endmodule

// File: tb/test_extirq_pin_ctrl.sv
module test_extirq_pin_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = '0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  irq_pin_o;
   logic        irq_any_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   extirq_pin_ctrl i_extirq_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pins),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pin_o(irq_pin_o), .irq_any_o(irq_any_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d); chk("R1 sense", d, 0);
      rd(3'd1, d); chk("R1 prio", d, 0);
      rd(3'd2, d); chk("R1 source", d, 0);
      rd(3'd5, d); chk("R1 mode", d, 0);
      chk("R1 irq_pin", irq_pin_o, 0);
      chk("R1 irq_any", irq_any_o, 0);

      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd5, 32'h0080_0000);
      // R1 all pins masked: pin0 high level pending but no request
      wr(3'd0, 32'h3000_0000);
      pins[0] = 1'b1;
      settle();
      rd(3'd2, d); chk("R1 pend visible", d, 32'h80);
      chk("R1 masked irq", irq_pin_o, 0);
      wr(3'd4, 32'hFF);
      chk("R6 unmask irq", irq_pin_o, 8'h01);
      pins[0] = 1'b0;
      wr(3'd0, 0);
      settle();
      wr(3'd2, 0);

      // R3 R4 R10 sweep over pins and trigger codes
      for (int n = 0; n < 8; n++) begin
         for (int m = 0; m < 6; m++) begin
            logic inact;
            logic [7:0] bit8;
            bit valid_code;
            bit level;
            inact = (m == 0 || m == 2);
            bit8 = 8'h80 >> n;
            valid_code = (m < 5);
            level = (m == 2 || m == 3);
            wr(3'd0, 32'(m) << (32 - (n + 1) * 4));
            pins[n] = inact;
            settle();
            wr(3'd2, 0);
            rd(3'd2, d); chk("R5 clear all", d, 0);
            pins[n] = ~inact;
            @(posedge clk); @(posedge clk); @(negedge clk);
            rd(3'd2, d); chk("R3 not before third edge", d, 0);
            @(posedge clk); @(negedge clk);
            rd(3'd2, d);
            if (m == 5) chk("R10 bad code no pend", d, 0);
            else if (level) chk("R4 level pend", d, 32'(bit8));
            else chk("R3 edge pend", d, 32'(bit8));
            chk("R9 irq_pin", irq_pin_o, valid_code ? (8'h01 << n) : 8'h00);
            chk("R9 irq_any", irq_any_o, valid_code);
            if (valid_code) begin
               wr(3'd2, 32'hFF);
               rd(3'd2, d); chk("R5 ones keep", d, 32'(bit8));
               wr(3'd2, 32'(~bit8));
               rd(3'd2, d);
               if (level) chk("R4 level re-set after clear", d, 32'(bit8));
               else chk("R5 single clear", d, 0);
               if (m == 4) begin
                  pins[n] = inact;
                  repeat (3) @(posedge clk);
                  @(negedge clk);
                  rd(3'd2, d); chk("R3 both edges second edge", d, 32'(bit8));
               end
            end
            pins[n] = inact;
            settle();
            wr(3'd2, 0);
            pins[n] = 1'b0;
            wr(3'd0, 0);
            settle();
            wr(3'd2, 0);
         end
      end

      // pin 2 high level for mask, priority and mode checks
      wr(3'd0, 32'h0030_0000);
      pins[2] = 1'b1;
      settle();
      rd(3'd2, d); chk("R4 pin2 pend", d, 32'h20);
      chk("R9 pin2 irq", irq_pin_o, 8'h04);
      rd(3'd0, d); chk("R2 sense readback", d, 32'h0030_0000);

      wr(3'd3, 0);
      chk("R6 zero mask write no effect", irq_pin_o, 8'h04);
      wr(3'd3, 32'h20);
      chk("R6 masked irq_pin", irq_pin_o, 0);
      chk("R6 masked irq_any", irq_any_o, 0);
      rd(3'd2, d); chk("R6 pend still visible", d, 32'h20);
      rd(3'd3, d); chk("R6 mask set reads 0", d, 0);
      rd(3'd4, d); chk("R6 mask clr reads 0", d, 0);
      wr(3'd4, 32'hDF);
      chk("R6 other clr bits no effect", irq_pin_o, 0);
      wr(3'd4, 32'h20);
      chk("R6 unmasked again", irq_pin_o, 8'h04);

      wr(3'd1, 32'hFF0F_FFFF);
      chk("R7 zero prio blocks pin", irq_pin_o, 0);
      chk("R7 zero prio blocks any", irq_any_o, 0);
      rd(3'd2, d); chk("R7 pend kept", d, 32'h20);
      wr(3'd1, 32'hFF1F_FFFF);
      chk("R7 nonzero prio passes", irq_pin_o, 8'h04);
      rd(3'd1, d); chk("R7 prio readback", d, 32'hFF1F_FFFF);

      wr(3'd5, 0);
      chk("R8 group mode pins off", irq_pin_o, 0);
      chk("R8 group mode any on", irq_any_o, 1);
      rd(3'd5, d); chk("R8 mode reads 0", d, 0);
      wr(3'd5, 32'h0080_0000);
      chk("R8 individual mode", irq_pin_o, 8'h04);
      rd(3'd5, d); chk("R8 mode readback", d, 32'h0080_0000);

      // R9 two pins at once: pin 5 rising edge, field offset 8
      wr(3'd0, 32'h0030_0100);
      pins[5] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 two requests", irq_pin_o, 8'h24);
      rd(3'd2, d); chk("R5 two sources", d, 32'h24);
      wr(3'd3, 32'h20);
      chk("R9 any with one left", irq_any_o, 1);

      // R2 full readback of a pattern
      wr(3'd0, 32'h1234_0004);
      rd(3'd0, d); chk("R2 sense pattern", d, 32'h1234_0004);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule